// File: doc/BRIEF.md
# Mode-Banked Register File

This block holds the sixteen general registers of a processor core, together with its status word and the saved copies of that word. Which physical storage cell a logical register number reaches depends on the mode field in the low five bits of the status word. User and system modes see one shared set of registers. Each of the five exception modes (fast interrupt, interrupt, supervisor, abort and undefined) has its own stack pointer and link register. The fast-interrupt mode also has its own registers 8 to 12. Registers 0 to 7 and register 15 are common to every mode.

The core reads two registers and writes one each cycle. An exception-entry strobe does several things at one clock edge: it writes the return address into the link register of the target mode, saves the current status word into that mode's saved status register, and switches the mode field. An exception-return strobe reloads the status word from the saved status register of the current mode, which restores the previous register mapping. A separate status write port lets software change the status word directly.

Top module: `rbank_regfile`

## Requirements
- R1: Logical registers 0 to 7 and 15 reach the same storage in every mode.
- R2: Registers 8 to 12 have a private copy in fast-interrupt mode (code 0x11). All other modes share a single copy of them.
- R3: Registers 13 and 14 have a private copy in each of the modes 0x11 (fast interrupt), 0x12 (interrupt), 0x13 (supervisor), 0x17 (abort) and 0x1B (undefined). User (0x10) and system (0x1F) share one copy.
- R4: A read index is sampled at a clock edge, and its data appears on the read output just after that edge, using the mode held before the edge. A write to the same physical register at that edge is forwarded to the output.
- R5: Exception entry with a target of 0x11, 0x12, 0x13, 0x17 or 0x1B does three things: the return address goes into the target's register 14, the old status word goes into the target's saved status register, and status bits [4:0] become the target code while the upper bits are kept.
- R6: An entry strobe whose target is not one of those five codes changes nothing. The other inputs then act as if the strobe were low.
- R7: Exception return loads the status word from the saved status register of the current mode. In user mode, system mode or an invalid mode it has no effect.
- R8: The saved-status output shows the saved status register of the current mode, or the status word itself in user, system or an invalid mode.
- R9: A mode code outside the seven listed codes selects the user registers and raises mode_err.
- R10: The status write port loads the whole status word. The priority order is valid entry, then return, then status write; a lower-priority request in the same cycle is dropped.
- R11: A register write in the same cycle as a valid exception entry is discarded.
- R12: After reset, the status word is 0x13, and all registers, saved status registers and read outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_a_idx | input | 4 | Logical index, read port A |
| rd_b_idx | input | 4 | Logical index, read port B |
| rd_a_data | output | DATA_W | Registered read data, port A |
| rd_b_data | output | DATA_W | Registered read data, port B |
| wr_en | input | 1 | Register write enable |
| wr_idx | input | 4 | Logical index to write |
| wr_data | input | DATA_W | Write data |
| sts_we | input | 1 | Status word write enable |
| sts_wdata | input | DATA_W | New status word |
| exc_enter | input | 1 | Exception entry strobe |
| exc_mode | input | 5 | Target mode code for entry |
| exc_ret_addr | input | DATA_W | Return address for the target link register |
| exc_return | input | 1 | Exception return strobe |
| status | output | DATA_W | Current status word |
| saved_status | output | DATA_W | Saved status of the current mode |
| mode_err | output | 1 | Current mode code is invalid |

## Verification
A wrong bank mapping does not show up until a register is read in another mode that should, or should not, share it. It then appears on a read output one cycle after that read is issued, and the bench reads across mode switches to expose this. A corrupted saved status register shows immediately on saved_status, and on status one cycle after an exception return. A link register that was dropped or misrouted on entry shows on the first read of register 14 in the target mode. Random traffic mixes entries, returns and status writes in the same cycle, so any error in the priority order shows on status at the next edge.

// File: rtl/rbank_pkg.sv
`timescale 1ns/1ps
package rbank_pkg;
  localparam int IDX_W     = 4;
  localparam int MODE_W    = 5;
  localparam int NUM_SAVED = 5;
  // physical layout
  localparam int P_HI_FIQ_OFF = 5;   // r8..r12 fiq copies at 13..17
  localparam int P_SPLR_USR   = 18;  // user/system r13,r14
  localparam int P_SPLR_EXC   = 20;  // per exception mode r13,r14 pairs
  localparam int P_PC         = P_SPLR_EXC + 2 * NUM_SAVED;
  localparam int NUM_PHYS     = P_PC + 1;
  localparam int PHYS_W       = $clog2(NUM_PHYS);

  localparam logic [MODE_W-1:0] MD_USR = 5'h10;
  localparam logic [MODE_W-1:0] MD_FIQ = 5'h11;
  localparam logic [MODE_W-1:0] MD_IRQ = 5'h12;
  localparam logic [MODE_W-1:0] MD_SVC = 5'h13;
  localparam logic [MODE_W-1:0] MD_ABT = 5'h17;
  localparam logic [MODE_W-1:0] MD_UND = 5'h1B;
  localparam logic [MODE_W-1:0] MD_SYS = 5'h1F;

  typedef enum logic [2:0] {
    BK_USR = 3'd0, BK_FIQ = 3'd1, BK_IRQ = 3'd2,
    BK_SVC = 3'd3, BK_ABT = 3'd4, BK_UND = 3'd5
  } bank_e;

  function automatic bank_e mode_bank(input logic [MODE_W-1:0] m);
    case (m)
      MD_FIQ:  return BK_FIQ;
      MD_IRQ:  return BK_IRQ;
      MD_SVC:  return BK_SVC;
      MD_ABT:  return BK_ABT;
      MD_UND:  return BK_UND;
      default: return BK_USR;
    endcase
  endfunction

  function automatic logic mode_valid(input logic [MODE_W-1:0] m);
    case (m)
      MD_USR, MD_FIQ, MD_IRQ, MD_SVC, MD_ABT, MD_UND, MD_SYS: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic is_exc_mode(input logic [MODE_W-1:0] m);
    return mode_valid(m) && (mode_bank(m) != BK_USR);
  endfunction
endpackage

// File: rtl/rbank_map.sv
`timescale 1ns/1ps
module rbank_map
  import rbank_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  input  logic [IDX_W-1:0]  idx,
  output logic [PHYS_W-1:0] phys
);
  bank_e bk;
  int    p;
  int    li;

  always_comb begin
    bk = mode_bank(mode);
    li = int'(idx);
    if (li < 8) begin
      p = li;
    end else if (li == 15) begin
      p = P_PC;
    end else if (li <= 12) begin
      p = (bk == BK_FIQ) ? li + P_HI_FIQ_OFF : li;
    end else if (bk == BK_USR) begin
      p = P_SPLR_USR + (li - 13);
    end else begin
      p = P_SPLR_EXC + 2 * (int'(bk) - 1) + (li - 13);
    end
    phys = PHYS_W'(p);
  end
endmodule

// File: rtl/rbank_store.sv
`timescale 1ns/1ps
module rbank_store #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 31,
  parameter int AW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr_a,
  input  logic [AW-1:0]     raddr_b,
  output logic [DATA_W-1:0] rdata_a,
  output logic [DATA_W-1:0] rdata_b
);
  logic [DATA_W-1:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    always_ff @(posedge clk) begin
      if (rst) mem[g] <= '0;
      else if (we && (int'(waddr) == g)) mem[g] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_a <= '0;
      rdata_b <= '0;
    end else begin
      rdata_a <= (we && waddr == raddr_a) ? wdata : mem[raddr_a];
      rdata_b <= (we && waddr == raddr_b) ? wdata : mem[raddr_b];
    end
  end
endmodule

// File: rtl/rbank_status.sv
`timescale 1ns/1ps
module rbank_status
  import rbank_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] RST_STATUS = 'h13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enter,
  input  logic [MODE_W-1:0] enter_mode,
  input  logic              ret,
  input  logic              sts_we,
  input  logic [DATA_W-1:0] sts_wdata,
  output logic              enter_ok,
  output logic [DATA_W-1:0] status,
  output logic [DATA_W-1:0] saved_status
);
  logic [DATA_W-1:0] saved_q [1:NUM_SAVED];
  bank_e             cur_bk;
  bank_e             tgt_bk;

  assign enter_ok = enter && is_exc_mode(enter_mode);
  assign tgt_bk   = mode_bank(enter_mode);
  assign cur_bk   = mode_bank(status[MODE_W-1:0]);

  for (genvar g = 1; g <= NUM_SAVED; g++) begin : g_saved
    always_ff @(posedge clk) begin
      if (rst) saved_q[g] <= '0;
      else if (enter_ok && int'(tgt_bk) == g) saved_q[g] <= status;
    end
  end

  always_comb begin
    saved_status = status;
    for (int g = 1; g <= NUM_SAVED; g++) begin
      if (int'(cur_bk) == g) saved_status = saved_q[g];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= RST_STATUS;
    end else if (enter_ok) begin
      status <= {status[DATA_W-1:MODE_W], enter_mode};
    end else if (ret) begin
      if (cur_bk != BK_USR) status <= saved_status;
    end else if (sts_we) begin
      status <= sts_wdata;
    end
  end
endmodule

// File: rtl/rbank_regfile.sv
`timescale 1ns/1ps
module rbank_regfile
  import rbank_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] RST_STATUS = 'h13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        rd_a_idx,
  input  logic [3:0]        rd_b_idx,
  output logic [DATA_W-1:0] rd_a_data,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              wr_en,
  input  logic [3:0]        wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              sts_we,
  input  logic [DATA_W-1:0] sts_wdata,
  input  logic              exc_enter,
  input  logic [4:0]        exc_mode,
  input  logic [DATA_W-1:0] exc_ret_addr,
  input  logic              exc_return,
  output logic [DATA_W-1:0] status,
  output logic [DATA_W-1:0] saved_status,
  output logic              mode_err
);
  localparam logic [IDX_W-1:0] LR_IDX = IDX_W'(14);

  logic [PHYS_W-1:0] ph_a, ph_b, ph_w, ph_lr;
  logic [PHYS_W-1:0] w_addr;
  logic [DATA_W-1:0] w_data;
  logic              w_en;
  logic              enter_ok;
  logic [MODE_W-1:0] cur_mode;

  assign cur_mode = status[MODE_W-1:0];

  rbank_map u_map_a  (.mode(cur_mode), .idx(rd_a_idx), .phys(ph_a));
  rbank_map u_map_b  (.mode(cur_mode), .idx(rd_b_idx), .phys(ph_b));
  rbank_map u_map_w  (.mode(cur_mode), .idx(wr_idx),   .phys(ph_w));
  rbank_map u_map_lr (.mode(exc_mode), .idx(LR_IDX),   .phys(ph_lr));

  rbank_status #(.DATA_W(DATA_W), .RST_STATUS(RST_STATUS)) u_status (
    .clk(clk), .rst(rst),
    .enter(exc_enter), .enter_mode(exc_mode), .ret(exc_return),
    .sts_we(sts_we), .sts_wdata(sts_wdata),
    .enter_ok(enter_ok), .status(status), .saved_status(saved_status)
  );

  // single effective write port: entry owns it, plain write otherwise
  always_comb begin
    if (enter_ok) begin
      w_en   = 1'b1;
      w_addr = ph_lr;
      w_data = exc_ret_addr;
    end else begin
      w_en   = wr_en;
      w_addr = ph_w;
      w_data = wr_data;
    end
  end

  rbank_store #(.DATA_W(DATA_W), .DEPTH(NUM_PHYS), .AW(PHYS_W)) u_store (
    .clk(clk), .rst(rst),
    .we(w_en), .waddr(w_addr), .wdata(w_data),
    .raddr_a(ph_a), .raddr_b(ph_b),
    .rdata_a(rd_a_data), .rdata_b(rd_b_data)
  );

  assign mode_err = !mode_valid(cur_mode);
endmodule

// File: rtl/rbank_chk.sv
`timescale 1ns/1ps
module rbank_chk
  import rbank_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              exc_enter,
  input logic [4:0]        exc_mode,
  input logic              exc_return,
  input logic              sts_we,
  input logic              wr_en,
  input logic [3:0]        wr_idx,
  input logic [DATA_W-1:0] wr_data,
  input logic [3:0]        rd_a_idx,
  input logic [DATA_W-1:0] rd_a_data,
  input logic [DATA_W-1:0] status,
  input logic [DATA_W-1:0] saved_status,
  input logic              mode_err
);
  logic good_entry;
  logic has_saved;
  assign good_entry = exc_enter && is_exc_mode(exc_mode);
  assign has_saved  = is_exc_mode(status[4:0]);

  // R5
  entry_mode_chk: assert property (@(posedge clk) disable iff (rst)
    good_entry |=> status[4:0] == $past(exc_mode));

  // R5
  entry_saved_chk: assert property (@(posedge clk) disable iff (rst)
    good_entry |=> saved_status == $past(status));

  // R6
  bad_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (exc_enter && !good_entry && !exc_return && !sts_we) |=> $stable(status));

  // R7
  return_chk: assert property (@(posedge clk) disable iff (rst)
    (exc_return && !good_entry && has_saved) |=> status == $past(saved_status));

  // R8
  err_saved_chk: assert property (@(posedge clk) disable iff (rst)
    mode_err |-> saved_status == status);

  // R4
  forward_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !good_entry && wr_idx == rd_a_idx) |=> rd_a_data == $past(wr_data));
endmodule

bind rbank_regfile rbank_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/test_rbank_regfile.sv
`timescale 1ns/1ps
module test_rbank_regfile;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
  logic [31:0] rd_a_data, rd_b_data, wr_data = '0, sts_wdata = '0;
  logic [31:0] exc_ret_addr = '0, status, saved_status;
  logic        wr_en = 1'b0, sts_we = 1'b0, exc_enter = 1'b0, exc_return = 1'b0;
  logic [4:0]  exc_mode = '0;
  logic        mode_err;

  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  rbank_regfile i_rbank_regfile (.*);

  // reference model: one full view of 16 registers per bank
  logic [31:0] m_reg [6][16];
  logic [31:0] m_saved [6];
  logic [31:0] m_sts;
  logic [31:0] e_a, e_b, e_sts, e_saved;
  logic        e_err;

  function automatic int bank_of(input logic [4:0] m);
    case (m)
      5'h11: return 1;
      5'h12: return 2;
      5'h13: return 3;
      5'h17: return 4;
      5'h1B: return 5;
      default: return 0;
    endcase
  endfunction

  function automatic logic valid_mode(input logic [4:0] m);
    return (m == 5'h10) || (m == 5'h1F) || (bank_of(m) != 0);
  endfunction

  task automatic shared_write(input int b, input int i, input logic [31:0] d);
    for (int c = 0; c < 6; c++) begin
      if (i < 8 || i == 15 || c == b ||
          (i <= 12 && ((b == 1) == (c == 1))))
        m_reg[c][i] = d;
    end
  endtask

  task automatic model_step();
    int cur, tb, nb;
    cur = bank_of(m_sts[4:0]);
    if (exc_enter && valid_mode(exc_mode) && bank_of(exc_mode) != 0) begin
      tb = bank_of(exc_mode);
      shared_write(tb, 14, exc_ret_addr);
      m_saved[tb] = m_sts;
      m_sts = {m_sts[31:5], exc_mode};
    end else begin
      if (wr_en) shared_write(cur, int'(wr_idx), wr_data);
      if (exc_return) begin
        if (cur != 0) m_sts = m_saved[cur];
      end else if (sts_we) begin
        m_sts = sts_wdata;
      end
    end
    e_a     = m_reg[cur][rd_a_idx];
    e_b     = m_reg[cur][rd_b_idx];
    e_sts   = m_sts;
    nb      = bank_of(m_sts[4:0]);
    e_saved = (nb == 0) ? m_sts : m_saved[nb];
    e_err   = !valid_mode(m_sts[4:0]);
  endtask

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic do_cycle(input string tag);
    model_step();
    @(posedge clk);
    @(negedge clk);
    chk(tag, "rd_a", rd_a_data, e_a);
    chk(tag, "rd_b", rd_b_data, e_b);
    chk(tag, "status", status, e_sts);
    chk(tag, "saved", saved_status, e_saved);
    chk(tag, "mode_err", {31'd0, mode_err}, {31'd0, e_err});
  endtask

  task automatic idle();
    wr_en = 0; sts_we = 0; exc_enter = 0; exc_return = 0;
  endtask

  task automatic set_mode(input logic [4:0] m, input string tag);
    idle(); sts_we = 1; sts_wdata = {27'h7800000, m}; do_cycle(tag); idle();
  endtask

  function automatic logic [4:0] pick_mode();
    logic [4:0] tbl [8];
    tbl = '{5'h10, 5'h11, 5'h12, 5'h13, 5'h17, 5'h1B, 5'h1F, 5'h05};
    return tbl[$urandom % 8];
  endfunction

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h1234);
    for (int c = 0; c < 6; c++) begin
      m_saved[c] = '0;
      for (int i = 0; i < 16; i++) m_reg[c][i] = '0;
    end
    m_sts = 32'h13;
    repeat (3) @(negedge clk);
    rst = 0;
    // R12 reset state
    chk("R12", "status", status, 32'h13);
    chk("R12", "saved", saved_status, 32'h0);
    chk("R12", "rd_a", rd_a_data, 32'h0);
    chk("R12", "mode_err", {31'd0, mode_err}, 32'h0);
    // R4 write then same-cycle read forward
    wr_en = 1; wr_idx = 0; wr_data = 32'hA0A0_0001; rd_a_idx = 0; rd_b_idx = 1;
    do_cycle("R4"); idle();
    // R10 status write, R1 common register in user mode
    set_mode(5'h10, "R10");
    rd_a_idx = 0; do_cycle("R1");
    // R3 user/system share r13
    wr_en = 1; wr_idx = 13; wr_data = 32'h1313_0013; do_cycle("R3"); idle();
    set_mode(5'h1F, "R3");
    rd_a_idx = 13; do_cycle("R3");
    // R2 fiq private r8
    set_mode(5'h11, "R2");
    wr_en = 1; wr_idx = 8; wr_data = 32'h8888_0008; do_cycle("R2"); idle();
    set_mode(5'h12, "R2");
    rd_a_idx = 8; do_cycle("R2");
    set_mode(5'h11, "R2");
    rd_a_idx = 8; do_cycle("R2");
    // R5 entry from fiq into irq
    exc_enter = 1; exc_mode = 5'h12; exc_ret_addr = 32'hCAFE_0004; do_cycle("R5"); idle();
    rd_a_idx = 14; rd_b_idx = 13; do_cycle("R5");
    // R6 entry with non-exception targets
    exc_enter = 1; exc_mode = 5'h10; exc_ret_addr = 32'h1111; do_cycle("R6");
    exc_mode = 5'h1F; do_cycle("R6");
    exc_mode = 5'h05; do_cycle("R6"); idle();
    // R11 write discarded during entry into svc
    exc_enter = 1; exc_mode = 5'h13; exc_ret_addr = 32'hBEEF_0008;
    wr_en = 1; wr_idx = 0; wr_data = 32'hDEAD_DEAD; do_cycle("R11"); idle();
    rd_a_idx = 0; rd_b_idx = 14; do_cycle("R11");
    // R7 returns unwind svc -> irq -> fiq
    exc_return = 1; do_cycle("R7");
    do_cycle("R7"); idle();
    set_mode(5'h10, "R7");
    exc_return = 1; sts_we = 1; sts_wdata = 32'h13; do_cycle("R7"); idle();
    // R8 saved output in user mode equals status
    rd_a_idx = 1; do_cycle("R8");
    // R9 invalid mode uses user bank
    set_mode(5'h05, "R9");
    rd_a_idx = 13; rd_b_idx = 8; do_cycle("R9");
    // R10 priority: entry beats return and status write
    exc_enter = 1; exc_mode = 5'h17; exc_ret_addr = 32'h5555; exc_return = 1;
    sts_we = 1; sts_wdata = 32'h1B; do_cycle("R10"); idle();
    exc_return = 1; sts_we = 1; sts_wdata = 32'h1B; do_cycle("R10"); idle();
    // random phase
    for (int k = 0; k < 3000; k++) begin
      int r;
      r = int'($urandom % 100);
      rd_a_idx = 4'($urandom); rd_b_idx = 4'($urandom);
      wr_en = ($urandom % 2) == 0; wr_idx = 4'($urandom); wr_data = $urandom;
      exc_enter = r < 10; exc_mode = pick_mode(); exc_ret_addr = $urandom;
      exc_return = (r >= 10 && r < 20) || (r < 3);
      sts_we = (r >= 15 && r < 28);
      sts_wdata = {27'($urandom), pick_mode()};
      do_cycle("R4");
    end
    idle();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule